// File: doc/BRIEF.md
# Horizontal Raster Timing Generator

This block generates the per-line horizontal timing of a character-based raster video controller. A character counter advances once per character-clock enable and wraps at a programmable line length. Comparisons against programmed values give three outputs: a display-enable window, a horizontal blanking interval and a horizontal retrace (sync) pulse. A one-character-clock end-of-line strobe tells the vertical generator to step to the next line.

The stop points for blanking and retrace compare only the low counter bits: 6 bits for blanking and 5 bits for retrace. Each interval therefore ends at the first later count whose low bits match. Display enable and the retrace pulse can each be delayed by 0 to 3 character clocks. The register values arrive as plain inputs. They are expected to hold steady while the block runs.

Top module: `htiming_gen`

## Requirements
- R1: `hcount` counts 0, 1, ... up to `reg_total + 4`, then returns to 0, so a line lasts `reg_total + 5` character clocks. It advances only on clocks where `cc_en` is 1.
- R2: `eol` is 1 exactly while `hcount` equals `reg_total + 4`. This lasts one character clock per line.
- R3: With zero display skew, `disp_en` is 1 for counts 0 through `reg_disp_end` inclusive and 0 for all later counts in the line.
- R4: Bits 6:5 of `reg_blank_end` give a display skew of 0 to 3. `disp_en` then shows the undelayed window value from that many character clocks earlier, and shows 0 in the clocks before that many have passed since reset.
- R5: `hblank` is 1 whenever `hcount` equals `reg_blank_start`, whatever the end value is.
- R6: Once started, `hblank` stays 1 up to the first later count whose low 6 bits equal the 6-bit end value, and is 0 on that count. The end value's bit 5 is `reg_retr_end[7]` and its bits 4:0 are `reg_blank_end[4:0]`. An end value equal to the start count's low 6 bits holds blanking for 64 counts.
- R7: The undelayed retrace is 1 from the count equal to `reg_retr_start` up to the first later count whose low 5 bits equal `reg_retr_end[4:0]`, and is 0 on that count. An end value equal to the start's low 5 bits gives 32 counts.
- R8: Bits 6:5 of `reg_retr_end` delay `hsync` by 0 to 3 character clocks, in the same way that R4 delays display enable.
- R9: While `cc_en` is 0, `hcount`, `disp_en`, `hblank`, `hsync` and `eol` keep their values.
- R10: A synchronous active-high `rst` holds `hcount` at 0 and holds `hblank` and `hsync` low. It also clears both skew pipelines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_en | input | 1 | Character-clock enable |
| reg_total | input | 8 | Line length minus 5 |
| reg_disp_end | input | 8 | Last displayed count |
| reg_blank_start | input | 8 | Blanking start count |
| reg_blank_end | input | 8 | [4:0] blank end low bits, [6:5] display skew |
| reg_retr_start | input | 8 | Retrace start count |
| reg_retr_end | input | 8 | [4:0] retrace end, [6:5] retrace skew, [7] blank end bit 5 |
| hcount | output | 9 | Character counter |
| disp_en | output | 1 | Display enable (skewed) |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal retrace (skewed) |
| eol | output | 1 | End-of-line strobe |

## Verification
The assertions assume that the register inputs stay constant from the end of reset until the next reset. In particular, the line length does not shrink below the current count. The stimulus meets this by changing register values only while `rst` is high. For each configuration it chooses start and end values so that every blanking and retrace interval closes inside the same line. Because of that choice, the expected waveform for each count can be computed directly from the start count and the modular distance to the end value.

// File: rtl/htiming_gen.sv
module htiming_gen #(
  parameter int CW  = 9,
  parameter int RW  = 8,
  parameter int SKW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cc_en,
  input  logic [RW-1:0] reg_total,
  input  logic [RW-1:0] reg_disp_end,
  input  logic [RW-1:0] reg_blank_start,
  input  logic [RW-1:0] reg_blank_end,
  input  logic [RW-1:0] reg_retr_start,
  input  logic [RW-1:0] reg_retr_end,
  output logic [CW-1:0] hcount,
  output logic          disp_en,
  output logic          hblank,
  output logic          hsync,
  output logic          eol
);
  localparam int DEPTH = (1 << SKW) - 1;

  logic [CW-1:0]  last;
  logic [5:0]     blank_stop;
  logic           blank_q, sync_q, de_raw, sync_raw;
  logic [DEPTH-1:0] de_pipe, sy_pipe;
  logic [DEPTH:0]   de_tap, sy_tap;
  logic [SKW-1:0]   de_skew, sy_skew;

  assign last       = CW'(reg_total) + CW'(4);
  assign blank_stop = {reg_retr_end[7], reg_blank_end[4:0]};
  assign de_skew    = reg_blank_end[6:5];
  assign sy_skew    = reg_retr_end[6:5];
  assign eol        = (hcount == last);

  assign de_raw   = (hcount <= CW'(reg_disp_end));
  assign hblank   = !rst && ((hcount == CW'(reg_blank_start)) ||
                             (blank_q && hcount[5:0] != blank_stop));
  assign sync_raw = !rst && ((hcount == CW'(reg_retr_start)) ||
                             (sync_q && hcount[4:0] != reg_retr_end[4:0]));

  assign de_tap  = {de_pipe, de_raw};
  assign sy_tap  = {sy_pipe, sync_raw};
  assign disp_en = de_tap[de_skew];
  assign hsync   = sy_tap[sy_skew];

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount  <= '0;
      blank_q <= 1'b0;
      sync_q  <= 1'b0;
      de_pipe <= '0;
      sy_pipe <= '0;
    end else if (cc_en) begin
      hcount  <= eol ? '0 : hcount + CW'(1);
      blank_q <= hblank;
      sync_q  <= sync_raw;
      de_pipe <= {de_pipe[DEPTH-2:0], de_raw};
      sy_pipe <= {sy_pipe[DEPTH-2:0], sync_raw};
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (cc_en && hcount == last) |=> hcount == '0);
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cc_en && hcount < last) |=> hcount == $past(hcount) + CW'(1));
  assert_eol_single_R2: assert property (@(posedge clk) disable iff (rst)
    (cc_en && eol) |=> !eol);
  assert_blank_start_R5: assert property (@(posedge clk) disable iff (rst)
    (hcount == CW'(reg_blank_start)) |-> hblank);
  assert_sync_start_R7: assert property (@(posedge clk) disable iff (rst)
    (hcount == CW'(reg_retr_start)) |-> sync_raw);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cc_en |=> ($stable(hcount) && $stable(blank_q) && $stable(sync_q)));
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (hcount == '0 && de_pipe == '0 && sy_pipe == '0));
endmodule

// File: tb/sim_htiming_gen.sv
`timescale 1ns/1ps
module sim_htiming_gen;
  logic clk = 1'b0, rst = 1'b1, cc_en = 1'b0;
  logic [7:0] reg_total = 8'd0, reg_disp_end = 8'd0, reg_blank_start = 8'd0;
  logic [7:0] reg_blank_end = 8'd0, reg_retr_start = 8'd0, reg_retr_end = 8'd0;
  logic [8:0] hcount;
  logic disp_en, hblank, hsync, eol;
  int nt = 0, nf = 0;

  always #2.5 clk = ~clk;

  htiming_gen u0 (.clk(clk), .rst(rst), .cc_en(cc_en), .reg_total(reg_total),
    .reg_disp_end(reg_disp_end), .reg_blank_start(reg_blank_start),
    .reg_blank_end(reg_blank_end), .reg_retr_start(reg_retr_start),
    .reg_retr_end(reg_retr_end), .hcount(hcount), .disp_en(disp_en),
    .hblank(hblank), .hsync(hsync), .eol(eol));

  task automatic chk(input string req, input int act, input int exp);
    nt++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one register set; end values chosen so every window closes inside the line.
  task automatic run_cfg(input int tot, input int de, input int bs, input int be6,
                         input int rs, input int re5, input int dsk, input int ssk,
                         input bit gaps);
    int len, kb, ks, n, c, m, cyc;
    len = tot + 5;
    kb = (be6 - bs) & 63; if (kb == 0) kb = 64;
    ks = (re5 - rs) & 31; if (ks == 0) ks = 32;
    @(negedge clk);
    rst = 1'b1; cc_en = 1'b1;
    reg_total = 8'(tot); reg_disp_end = 8'(de); reg_blank_start = 8'(bs);
    reg_retr_start = 8'(rs);
    reg_blank_end = {1'b0, 2'(dsk), 5'(be6)};
    reg_retr_end  = {1'(be6 >> 5), 2'(ssk), 5'(re5)};
    @(posedge clk); @(negedge clk);
    chk("R10 count in reset", hcount, 0);
    chk("R10 blank in reset", hblank, 0);
    chk("R10 sync in reset", hsync, 0);
    rst = 1'b0;
    n = 0; cyc = 0;
    while (n < 2 * len + 4) begin
      c = n % len;
      chk("R1 count", hcount, c);
      chk("R2 eol", eol, int'(c == len - 1));
      chk("R5 R6 blank", hblank, int'(c >= bs && c < bs + kb));
      m = n - dsk;
      chk(dsk == 0 ? "R3 display" : "R4 display skew", disp_en,
          m < 0 ? 0 : int'((m % len) <= de));
      m = n - ssk;
      chk(ssk == 0 ? "R7 sync" : "R8 sync skew", hsync,
          m < 0 ? 0 : int'((m % len) >= rs && (m % len) < rs + ks));
      cc_en = gaps ? (cyc % 3 != 0) : 1'b1;
      if (!cc_en) begin
        @(posedge clk); @(negedge clk);
        cyc++;
        chk("R9 hold count", hcount, c);
        cc_en = 1'b1;
      end
      @(posedge clk);
      n++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    nt++; nf++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    run_cfg(35, 31, 32, 38, 34, 5, 0, 0, 1'b0);
    run_cfg(59, 47, 50, 60, 52, 24, 2, 3, 1'b1);
    run_cfg(123, 99, 40, 40, 90, 26, 1, 1, 1'b0);
    run_cfg(255, 255, 200, 28, 210, 28, 3, 0, 1'b0);
    run_cfg(3, 1, 2, 3, 0, 2, 0, 2, 1'b1);
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule